// File: doc/BRIEF.md
# Posted-Write Error Capture Registers

A bridge that posts writes sends the write acknowledgement upstream before the downstream bus has finished the transfer. If the downstream side later reports a slave error or a timeout, the upstream master has nothing left to receive that news. This block closes the gap. It watches two downstream strobes, one for a write error and one for a write timeout. On the first failure it latches the address of the write in flight and its control qualifiers, which are burst length, beat size, burst type, cache attributes and protection. It then raises a level interrupt.

Software reaches the captured record through a four-register AXI4-Lite slave. Reading the status word hands the record to software and re-arms the capture. The interrupt pin is gated by a global enable bit and by a per-source enable bit. The AXI4-Lite channels follow valid/ready rules with back-pressure. A write is accepted only when its address and data arrive together and no earlier response is still waiting. A read is accepted only when no earlier read data is still waiting. A response stays on its channel, unchanged, until the master takes it. The error strobes and the interrupt are plain level or pulse pins with no handshake.

Top module: `pwerr_capture_regs`

## Requirements
- R1: After reset every register reads 0x0 and `irq_o` is low.
- R2: The word offsets are as follows: 0x0 is the status register, 0x4 is the error address, 0x8 is the global interrupt enable and 0xC is the interrupt enable. Only address bits [CSR_AW-1:2] are decoded.
- R3: When no record is held, a high on `err_wr_i` or `err_tmo_i` at a clock edge captures the transaction inputs. From the next cycle the status reads as follows: bit 0 is 1 (valid), bit 1 holds the error strobe, bit 2 holds the timeout strobe, bits [10:3] hold the length, [13:11] the size, [15:14] the burst type, [19:16] the cache attributes and [22:20] the protection. All higher bits are zero. The address register returns the captured address.
- R4: While a record is held, further error or timeout strobes change neither the status nor the address register.
- R5: An accepted read of offset 0x0 returns the status as it was and clears the whole status register to zero. If a strobe arrives in the same cycle as that read, it is captured as a new record.
- R6: The address register keeps its value after the status is cleared, until the next capture. Writes to offset 0x4 have no effect.
- R7: The two enable registers are read/write in bit 0 only. Bit 0 is written only when write strobe bit 0 is set. All other bits read zero.
- R8: `irq_o` is high exactly when the global enable, the interrupt enable and the valid flag are all 1.
- R9: Writes to read-only or unmapped offsets (0x10 to 0x1C) change nothing. Reads of unmapped offsets return zero. Every write and read response is OKAY (code 0).
- R10: Write address and data are accepted together only while no write response is pending. A read is accepted only while no read data is pending. `bvalid` and `rvalid` with their payloads hold steady until `bready` or `rready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_wr_i | input | 1 | Downstream write-error strobe |
| err_tmo_i | input | 1 | Downstream write-timeout strobe |
| txn_addr_i | input | ADDR_W | Address of the write in flight |
| txn_len_i | input | LEN_W | Burst length of the write in flight |
| txn_size_i | input | SIZE_W | Beat size of the write in flight |
| txn_burst_i | input | BURST_W | Burst type of the write in flight |
| txn_cache_i | input | CACHE_W | Cache attributes of the write in flight |
| txn_prot_i | input | PROT_W | Protection attributes of the write in flight |
| s_axil_awaddr | input | CSR_AW | Write address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | 32 | Write data |
| s_axil_wstrb | input | 4 | Write byte strobes |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | CSR_AW | Read address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | 32 | Read data |
| s_axil_rresp | output | 2 | Read response |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a status read that is accepted in the same clock edge as a new error strobe. That read must return the old record, and the new failure must become the held record instead of being lost. The stimulus reaches this case by holding a record and then, at a single falling edge, driving the read address and the error strobe together, so that the handshake and the strobe meet at the following rising edge. The bench also holds `rready` and `bready` low across several cycles while a record is pending, to show that the held payloads do not move.

// File: rtl/pwerr_pkg.sv
package pwerr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned NUM_REGS = 4;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ADDR   = 2'd1,
    SEL_GIE    = 2'd2,
    SEL_IER    = 2'd3
  } reg_sel_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/pwerr_axil_port.sv
module pwerr_axil_port
  import pwerr_pkg::*;
#(
  parameter int unsigned CSR_AW = 5,
  localparam int unsigned IDX_W = CSR_AW - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CSR_AW-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [CSR_AW-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [STRB_W-1:0] wr_strb_o,
  output logic              rd_en_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  logic              bvalid_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic              wr_hs;
  logic              rd_hs;

  // address and data are taken only as a pair, and only with the response slot free
  assign awready = wvalid  && !bvalid_q;
  assign wready  = awvalid && !bvalid_q;
  assign arready = !rvalid_q;
  assign wr_hs   = awvalid && wvalid && !bvalid_q;
  assign rd_hs   = arvalid && !rvalid_q;

  assign wr_en_o   = wr_hs;
  assign wr_idx_o  = awaddr[CSR_AW-1:2];
  assign wr_data_o = wdata;
  assign wr_strb_o = wstrb;
  assign rd_en_o   = rd_hs;
  assign rd_idx_o  = araddr[CSR_AW-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
    end else if (wr_hs) begin
      bvalid_q <= 1'b1;
    end else if (bready) begin
      bvalid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (rd_hs) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_data_i;
    end else if (rready) begin
      rvalid_q <= 1'b0;
    end
  end

  assign bvalid = bvalid_q;
  assign bresp  = RESP_OKAY;
  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
  assign rresp  = RESP_OKAY;

  // R10
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);
  // R10
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
  // R10
  no_wr_over_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !(awready && wready));
  // R9
  okay_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid |-> bresp == 2'b00) and (rvalid |-> rresp == 2'b00));
endmodule

// File: rtl/pwerr_capture.sv
module pwerr_capture #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned FLD_W  = 20,
  localparam int unsigned REC_W = FLD_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_wr_i,
  input  logic              err_tmo_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [FLD_W-1:0]  fields_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic [REC_W-1:0]  rec_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              valid_q;
  logic [REC_W-1:0]  rec_q;
  logic [ADDR_W-1:0] addr_q;
  logic              event_seen;
  logic              take;

  assign event_seen = err_wr_i || err_tmo_i;
  // a clearing read frees the slot in the same edge, so a coincident failure is kept
  assign take = event_seen && (!valid_q || clr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rec_q   <= '0;
      addr_q  <= '0;
    end else if (take) begin
      valid_q <= 1'b1;
      rec_q   <= {fields_i, err_tmo_i, err_wr_i};
      addr_q  <= addr_i;
    end else if (clr_i) begin
      valid_q <= 1'b0;
      rec_q   <= '0;
    end
  end

  assign valid_o = valid_q;
  assign rec_o   = rec_q;
  assign addr_o  = addr_q;

  // R3
  arm_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && event_seen) |=> valid_q);
  // R4
  held_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clr_i) |=> ($stable(rec_q) && $stable(addr_q) && valid_q));
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !event_seen) |=> (!valid_q && rec_q == '0));
  // R6
  addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !event_seen |=> $stable(addr_q));
endmodule

// File: rtl/pwerr_irq_ctl.sv
module pwerr_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic gie_we_i,
  input  logic ier_we_i,
  input  logic bit_i,
  input  logic pend_i,
  output logic gie_o,
  output logic ier_o,
  output logic irq_o
);
  logic gie_q;
  logic ier_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      ier_q <= 1'b0;
    end else begin
      if (gie_we_i) gie_q <= bit_i;
      if (ier_we_i) ier_q <= bit_i;
    end
  end

  assign gie_o = gie_q;
  assign ier_o = ier_q;
  assign irq_o = gie_q && ier_q && pend_i;

  // R8
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_i |-> !irq_o);
  // R7
  gie_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_we_i |=> $stable(gie_q));
  // R7
  ier_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ier_we_i |=> $stable(ier_q));
endmodule

// File: rtl/pwerr_capture_regs.sv
module pwerr_capture_regs
  import pwerr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned SIZE_W  = 3,
  parameter int unsigned BURST_W = 2,
  parameter int unsigned CACHE_W = 4,
  parameter int unsigned PROT_W  = 3,
  parameter int unsigned CSR_AW  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               err_wr_i,
  input  logic               err_tmo_i,
  input  logic [ADDR_W-1:0]  txn_addr_i,
  input  logic [LEN_W-1:0]   txn_len_i,
  input  logic [SIZE_W-1:0]  txn_size_i,
  input  logic [BURST_W-1:0] txn_burst_i,
  input  logic [CACHE_W-1:0] txn_cache_i,
  input  logic [PROT_W-1:0]  txn_prot_i,
  input  logic [CSR_AW-1:0]  s_axil_awaddr,
  input  logic               s_axil_awvalid,
  output logic               s_axil_awready,
  input  logic [31:0]        s_axil_wdata,
  input  logic [3:0]         s_axil_wstrb,
  input  logic               s_axil_wvalid,
  output logic               s_axil_wready,
  output logic [1:0]         s_axil_bresp,
  output logic               s_axil_bvalid,
  input  logic               s_axil_bready,
  input  logic [CSR_AW-1:0]  s_axil_araddr,
  input  logic               s_axil_arvalid,
  output logic               s_axil_arready,
  output logic [31:0]        s_axil_rdata,
  output logic [1:0]         s_axil_rresp,
  output logic               s_axil_rvalid,
  input  logic               s_axil_rready,
  output logic               irq_o
);
  localparam int unsigned IDX_W  = CSR_AW - 2;
  localparam int unsigned FLD_W  = LEN_W + SIZE_W + BURST_W + CACHE_W + PROT_W;
  localparam int unsigned REC_W  = FLD_W + 2;
  localparam int unsigned STAT_W = REC_W + 1;

  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic [STRB_W-1:0] wr_strb;
  logic              rd_en;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_data;

  logic              cap_valid;
  logic [REC_W-1:0]  cap_rec;
  logic [ADDR_W-1:0] cap_addr;
  logic [FLD_W-1:0]  txn_fields;
  logic              stat_clr;
  logic              gie;
  logic              ier;
  logic              gie_we;
  logic              ier_we;
  logic              wr_mapped;
  logic              rd_mapped;
  reg_sel_e          wr_sel;
  reg_sel_e          rd_sel;
  logic [STAT_W-1:0] stat_word;

  pwerr_axil_port #(.CSR_AW(CSR_AW)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .awaddr   (s_axil_awaddr),
    .awvalid  (s_axil_awvalid),
    .awready  (s_axil_awready),
    .wdata    (s_axil_wdata),
    .wstrb    (s_axil_wstrb),
    .wvalid   (s_axil_wvalid),
    .wready   (s_axil_wready),
    .bresp    (s_axil_bresp),
    .bvalid   (s_axil_bvalid),
    .bready   (s_axil_bready),
    .araddr   (s_axil_araddr),
    .arvalid  (s_axil_arvalid),
    .arready  (s_axil_arready),
    .rdata    (s_axil_rdata),
    .rresp    (s_axil_rresp),
    .rvalid   (s_axil_rvalid),
    .rready   (s_axil_rready),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .wr_data_o(wr_data),
    .wr_strb_o(wr_strb),
    .rd_en_o  (rd_en),
    .rd_idx_o (rd_idx),
    .rd_data_i(rd_data)
  );

  // offsets beyond the fourth word decode to nothing
  assign wr_mapped = (wr_idx >> 2) == '0;
  assign rd_mapped = (rd_idx >> 2) == '0;
  assign wr_sel    = reg_sel_e'(wr_idx[1:0]);
  assign rd_sel    = reg_sel_e'(rd_idx[1:0]);

  assign txn_fields = {txn_prot_i, txn_cache_i, txn_burst_i, txn_size_i, txn_len_i};
  assign stat_clr   = rd_en && rd_mapped && (rd_sel == SEL_STATUS);

  pwerr_capture #(.ADDR_W(ADDR_W), .FLD_W(FLD_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_wr_i (err_wr_i),
    .err_tmo_i(err_tmo_i),
    .addr_i   (txn_addr_i),
    .fields_i (txn_fields),
    .clr_i    (stat_clr),
    .valid_o  (cap_valid),
    .rec_o    (cap_rec),
    .addr_o   (cap_addr)
  );

  assign gie_we = wr_en && wr_mapped && (wr_sel == SEL_GIE) && wr_strb[0];
  assign ier_we = wr_en && wr_mapped && (wr_sel == SEL_IER) && wr_strb[0];

  pwerr_irq_ctl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .gie_we_i(gie_we),
    .ier_we_i(ier_we),
    .bit_i   (wr_data[0]),
    .pend_i  (cap_valid),
    .gie_o   (gie),
    .ier_o   (ier),
    .irq_o   (irq_o)
  );

  assign stat_word = {cap_rec, cap_valid};

  always_comb begin
    rd_data = '0;
    if (rd_mapped) begin
      unique case (rd_sel)
        SEL_STATUS: rd_data = DATA_W'(stat_word);
        SEL_ADDR:   rd_data = DATA_W'(cap_addr);
        SEL_GIE:    rd_data = DATA_W'(gie);
        SEL_IER:    rd_data = DATA_W'(ier);
        default:    rd_data = '0;
      endcase
    end
  end

  initial begin
    // R3
    stat_fits_chk: assert (STAT_W <= DATA_W && ADDR_W <= DATA_W && CSR_AW >= 4);
  end

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (gie && ier));
  // R6
  addr_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_wr_i && !err_tmo_i) |=> $stable(cap_addr));
endmodule

// File: tb/tb_pwerr_capture_regs.sv
module tb_pwerr_capture_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_wr_i = 0, err_tmo_i = 0;
  logic [31:0] txn_addr_i = 0;
  logic [7:0]  txn_len_i = 0;
  logic [2:0]  txn_size_i = 0;
  logic [1:0]  txn_burst_i = 0;
  logic [3:0]  txn_cache_i = 0;
  logic [2:0]  txn_prot_i = 0;
  logic [4:0]  awaddr = 0, araddr = 0;
  logic        awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic [31:0] wdata = 0;
  logic [3:0]  wstrb = 4'hF;
  logic        awready, wready, bvalid, arready, rvalid, irq;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pwerr_capture_regs dut (
    .clk(clk), .rst_n(rst_n), .err_wr_i(err_wr_i), .err_tmo_i(err_tmo_i),
    .txn_addr_i(txn_addr_i), .txn_len_i(txn_len_i), .txn_size_i(txn_size_i),
    .txn_burst_i(txn_burst_i), .txn_cache_i(txn_cache_i), .txn_prot_i(txn_prot_i),
    .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
    .s_axil_wdata(wdata), .s_axil_wstrb(wstrb), .s_axil_wvalid(wvalid),
    .s_axil_wready(wready), .s_axil_bresp(bresp), .s_axil_bvalid(bvalid),
    .s_axil_bready(bready), .s_axil_araddr(araddr), .s_axil_arvalid(arvalid),
    .s_axil_arready(arready), .s_axil_rdata(rdata), .s_axil_rresp(rresp),
    .s_axil_rvalid(rvalid), .s_axil_rready(rready), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] stat_of(input bit e, input bit t, input int len,
      input int size, input int burst, input int cache, input int prot);
    return 32'(1 | (e << 1) | (t << 2) | (len << 3) | (size << 11) |
               (burst << 14) | (cache << 16) | (prot << 20));
  endfunction

  // behavioural reference model, stepped on each rising edge
  logic [31:0] m_stat = 0, m_addr = 0, m_rdata = 0;
  bit m_gie = 0, m_ier = 0, m_rvalid = 0, m_bvalid = 0;

  always @(posedge clk) begin
    int idx;
    bit ar_hs, wr_hs, clr, ev;
    cycles++;
    if (!rst_n) begin
      m_stat <= 0; m_addr <= 0; m_rdata <= 0;
      m_gie <= 0; m_ier <= 0; m_rvalid <= 0; m_bvalid <= 0;
    end else begin
      ar_hs = arvalid && !m_rvalid;
      wr_hs = awvalid && wvalid && !m_bvalid;
      idx   = int'(araddr) / 4;
      clr   = ar_hs && idx == 0;
      ev    = err_wr_i || err_tmo_i;
      if (ev && (m_stat[0] == 0 || clr)) begin
        m_stat <= stat_of(err_wr_i, err_tmo_i, txn_len_i, txn_size_i, txn_burst_i,
                          txn_cache_i, txn_prot_i);
        m_addr <= txn_addr_i;
      end else if (clr) begin
        m_stat <= 0;
      end
      if (ar_hs) begin
        m_rvalid <= 1;
        case (idx)
          0: m_rdata <= m_stat;
          1: m_rdata <= m_addr;
          2: m_rdata <= {31'b0, m_gie};
          3: m_rdata <= {31'b0, m_ier};
          default: m_rdata <= 0;
        endcase
      end else if (rready) begin
        m_rvalid <= 0;
      end
      if (wr_hs && wstrb[0]) begin
        if (int'(awaddr) / 4 == 2) m_gie <= wdata[0];
        if (int'(awaddr) / 4 == 3) m_ier <= wdata[0];
      end
      if (wr_hs) m_bvalid <= 1;
      else if (bready) m_bvalid <= 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(irq == (m_gie && m_ier && m_stat[0]), "R8 model irq", 32'(irq),
          32'(m_gie && m_ier && m_stat[0]));
      chk(rvalid == m_rvalid && arready == !m_rvalid, "R10 model rvalid",
          32'(rvalid), 32'(m_rvalid));
      chk(bvalid == m_bvalid, "R10 model bvalid", 32'(bvalid), 32'(m_bvalid));
      if (m_rvalid) chk(rdata == m_rdata && rresp == 0, "R2 model rdata", rdata, m_rdata);
      if (m_bvalid) chk(bresp == 0, "R9 model bresp", 32'(bresp), 0);
    end
  end

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1; bready = 1;
    #1;
    while (!awready) begin @(negedge clk); #1; end
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk(bvalid && bresp == 0, "R9 write response", {30'b0, bresp}, 0);
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1; rready = 1;
    #1;
    while (!arready) begin @(negedge clk); #1; end
    @(negedge clk);
    arvalid = 0;
    d = rdata;
  endtask

  task automatic rd_expect(input logic [4:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    reg_rd(a, d);
    chk(d == exp, tag, d, exp);
  endtask

  task automatic fault(input bit e, input bit t, input logic [31:0] a, input int len,
                       input int size, input int burst, input int cache, input int prot);
    @(negedge clk);
    err_wr_i = e; err_tmo_i = t; txn_addr_i = a;
    txn_len_i = 8'(len); txn_size_i = 3'(size); txn_burst_i = 2'(burst);
    txn_cache_i = 4'(cache); txn_prot_i = 3'(prot);
    @(negedge clk);
    err_wr_i = 0; err_tmo_i = 0;
  endtask

  task automatic report;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] s1, d;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    chk(irq == 0, "R1 irq after reset", 32'(irq), 0);
    rd_expect(5'h00, 0, "R1 status reset");
    rd_expect(5'h04, 0, "R1 address reset");
    rd_expect(5'h08, 0, "R1 gie reset");
    rd_expect(5'h0C, 0, "R1 ier reset");

    // R7 enables, bit 0 only, strobe gated
    reg_wr(5'h08, 32'h1, 4'h1);
    rd_expect(5'h08, 1, "R7 gie set");
    reg_wr(5'h0C, 32'hFFFF_FFFF, 4'hF);
    rd_expect(5'h0C, 1, "R7 ier upper bits zero");
    reg_wr(5'h08, 32'h0, 4'hE);
    rd_expect(5'h08, 1, "R7 gie kept without strobe bit 0");

    // R3 capture of a slave error, R8 interrupt follows
    s1 = stat_of(1, 0, 3, 2, 1, 3, 2);
    fault(1, 0, 32'h1234_5670, 3, 2, 1, 3, 2);
    chk(irq == 1, "R8 irq on capture", 32'(irq), 1);
    // R4 later timeout is ignored
    fault(0, 1, 32'hAAAA_0000, 255, 7, 3, 15, 7);
    rd_expect(5'h04, 32'h1234_5670, "R4 address held");
    // R6 write to address register ignored
    reg_wr(5'h04, 32'hDEAD_BEEF, 4'hF);
    rd_expect(5'h04, 32'h1234_5670, "R6 address write ignored");
    // R9 unmapped offsets
    reg_wr(5'h10, 32'hFFFF_FFFF, 4'hF);
    rd_expect(5'h10, 0, "R9 unmapped read 0x10");
    rd_expect(5'h1C, 0, "R9 unmapped read 0x1C");
    rd_expect(5'h08, 1, "R9 gie unchanged by unmapped write");
    // R5 read of status returns then clears
    rd_expect(5'h00, s1, "R3 status layout");
    chk(irq == 0, "R5 irq low after clear", 32'(irq), 0);
    rd_expect(5'h00, 0, "R5 status cleared");
    rd_expect(5'h04, 32'h1234_5670, "R6 address kept after clear");

    // R3 both strobes together
    fault(1, 1, 32'h0000_0FF0, 0, 0, 2, 0, 5);
    rd_expect(5'h04, 32'h0000_0FF0, "R3 recapture address");
    // R5 clearing read and new failure in one cycle
    @(negedge clk);
    araddr = 5'h00; arvalid = 1; rready = 1;
    err_wr_i = 1; txn_addr_i = 32'h5555_0004; txn_len_i = 8'd17; txn_size_i = 3'd1;
    txn_burst_i = 2'd2; txn_cache_i = 4'd9; txn_prot_i = 3'd1;
    @(negedge clk);
    arvalid = 0; err_wr_i = 0;
    chk(rdata == stat_of(1, 1, 0, 0, 2, 0, 5), "R5 coincident read returns old", rdata,
        stat_of(1, 1, 0, 0, 2, 0, 5));
    rd_expect(5'h00, stat_of(1, 0, 17, 1, 2, 9, 1), "R5 coincident failure kept");
    rd_expect(5'h04, 32'h5555_0004, "R5 coincident address kept");

    // R8 gating
    fault(0, 1, 32'h0000_0100, 1, 1, 1, 1, 1);
    reg_wr(5'h08, 32'h0, 4'hF);
    @(negedge clk);
    chk(irq == 0, "R8 gie off masks irq", 32'(irq), 0);
    reg_wr(5'h08, 32'h1, 4'hF);
    reg_wr(5'h0C, 32'h0, 4'hF);
    @(negedge clk);
    chk(irq == 0, "R8 ier off masks irq", 32'(irq), 0);
    reg_wr(5'h0C, 32'h1, 4'hF);
    @(negedge clk);
    chk(irq == 1, "R8 both enables raise irq", 32'(irq), 1);

    // R10 back-pressure on both response channels
    @(negedge clk);
    rready = 0; araddr = 5'h04; arvalid = 1;
    @(negedge clk);
    arvalid = 0;
    repeat (3) @(negedge clk);
    chk(rvalid && rdata == 32'h0000_0100, "R10 rdata held", rdata, 32'h0000_0100);
    chk(arready == 0, "R10 no second read", 32'(arready), 0);
    rready = 1;
    @(negedge clk);
    bready = 0; awaddr = 5'h08; wdata = 0; wstrb = 4'hF; awvalid = 1; wvalid = 1;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    repeat (3) @(negedge clk);
    chk(bvalid == 1, "R10 bvalid held", 32'(bvalid), 1);
    awvalid = 1; wvalid = 1; wdata = 1;
    #1;
    chk(awready == 0, "R10 write blocked while response pending", 32'(awready), 0);
    @(negedge clk);
    awvalid = 0; wvalid = 0; bready = 1;
    repeat (2) @(negedge clk);
    rd_expect(5'h08, 0, "R10 blocked write not taken");
    reg_rd(5'h00, d);
    repeat (3) @(negedge clk);
    report();
  end
endmodule